// File: doc/BRIEF.md
# Match-Compare Event Timer

This block is a memory-mapped event timer for a large chip. An up-counter advances once per tick. A programmable prescaler makes the tick from the bus clock, and the counter runs only while the run bit is set. The counter is compared against a programmable match value, and a one-cycle interrupt pulse is raised when the count arrives at that value. The counter can be set to return to zero on a match, which gives a periodic event, or it can run free and wrap around.

Zeroing the counter is a request, not an immediate action. The request is handed over to the tick-paced side of the block, and a completion flag is returned through a synchronizer. While the request is in flight, a pending bit is visible in the status register. Software should poll that bit until it is low before it sets the run bit again.

The bus is a simple single-cycle strobe interface. Read data is registered and appears on the cycle after the read request.

Top module: `mm_match_timer`

## Requirements
- R1: After reset, every readable register returns zero, `irq` is low and the pending bit is low.
- R2: Register layout (byte offsets): 0x00 match value (read/write); 0x04 count (read-only); 0x08 control, with bit 0 = run and bit 1 = zero-on-match; 0x0C zeroing strobe (write-only); 0x10 prescale setting in bits [1:0]; 0x14 status, with bit 10 = zeroing pending. Read data is presented on `bus_rdata` on the cycle after the request.
- R3: A prescale setting d produces one tick every d+1 clock cycles. The counter advances by one per tick while run is set, and it never changes between ticks.
- R4: While run is clear, the count holds its value.
- R5: With zero-on-match clear, the count wraps from its all-ones value to zero and keeps counting.
- R6: `irq` is high for exactly the cycle in which the count first shows a value equal to the match value, and only when that value was reached by counting.
- R7: With zero-on-match set, the tick after the count equals the match value loads zero, so events repeat every match+1 ticks.
- R8: With zero-on-match clear, the counter keeps counting after a match, and the next interrupt comes only after a full wrap back to the match value.
- R9: Any write to 0x0C, whatever the data, zeroes the count on the second tick after the write. This happens even while run is clear.
- R10: The pending bit reads high from the cycle after a zeroing write until two clock cycles after the zeroing takes effect.
- R11: Writes to the count register have no effect, and reads of the zeroing strobe return zero.
- R12: A tick that applies a zeroing neither increments the count nor raises `irq`, even when the count would otherwise have reached the match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | One-cycle event pulse on match |

## Verification
The zeroing request and the match compare can act on the same tick. The zeroing can land on the exact tick at which the count would step onto the match value, and in that case the zeroing must win and no interrupt may fire. The bench provokes this by issuing zeroing writes at a sweep of cycle offsets while the counter runs at full rate against a small match value, so some of the writes coincide with a match tick. Every clock, a behavioural model judges the interrupt line and every read value, including the pending bit as it is polled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BUS_W = 32;
   localparam logic [7:0] OFS_MATCH = 8'h00;
   localparam logic [7:0] OFS_COUNT = 8'h04;
   localparam logic [7:0] OFS_CTRL  = 8'h08;
   localparam logic [7:0] OFS_ZERO  = 8'h0C;
   localparam logic [7:0] OFS_PRESC = 8'h10;
   localparam logic [7:0] OFS_STAT  = 8'h14;
   localparam int PEND_POS = 10;

   typedef struct packed {
      logic zero_on_match;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] setting,
   output logic             tick
);
   logic [DIV_W-1:0] phase_q;

   assign tick = (phase_q == setting);

   always_ff @(posedge clk) begin
      if (!rst_n)
         phase_q <= '0;
      else if (tick)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end
endmodule

// File: rtl/tmr_zero_sync.sv
module tmr_zero_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic zero_req,
   output logic zero_apply,
   output logic pending
);
   logic req_tgl_q;
   logic cap_q;
   logic done_tgl_q;
   logic [SYNC_STAGES-1:0] ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         req_tgl_q <= 1'b0;
      else if (zero_req)
         req_tgl_q <= ~req_tgl_q;
   end

   assign zero_apply = tick && (cap_q != done_tgl_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q      <= 1'b0;
         done_tgl_q <= 1'b0;
      end else if (tick) begin
         cap_q <= req_tgl_q;
         if (cap_q != done_tgl_q)
            done_tgl_q <= cap_q;
      end
   end

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_ack
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) ack_q[0] <= 1'b0;
               else        ack_q[0] <= done_tgl_q;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) ack_q[s] <= 1'b0;
               else        ack_q[s] <= ack_q[s-1];
            end
         end
      end
   endgenerate

   assign pending = req_tgl_q ^ ack_q[SYNC_STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             zero_on_match,
   input  logic [CNT_W-1:0] match_val,
   input  logic             zero_apply,
   output logic [CNT_W-1:0] count_q,
   output logic             irq
);
   logic [CNT_W-1:0] nxt;
   logic             load;
   logic             counting;

   always_comb begin
      counting = tick && run && !zero_apply;
      load     = zero_apply || counting;
      if (zero_apply)
         nxt = '0;
      else if (zero_on_match && (count_q == match_val))
         nxt = '0;
      else
         nxt = count_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         irq     <= 1'b0;
      end else begin
         if (load)
            count_q <= nxt;
         irq <= counting && (nxt == match_val);
      end
   end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DIV_W  = 2,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic [CNT_W-1:0]  count_q,
   input  logic              pending,
   output logic [CNT_W-1:0]  match_q,
   output ctrl_t             ctrl_q,
   output logic [DIV_W-1:0]  presc_q,
   output logic              zero_req,
   output logic [BUS_W-1:0]  bus_rdata
);
   localparam int PAD_W = BUS_W - CNT_W;

   logic wr_en, rd_en;
   logic [BUS_W-1:0] match_ext, count_ext, rd_mux;

   assign wr_en = bus_sel && bus_wr;
   assign rd_en = bus_sel && !bus_wr;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ofs[ADDR_W-1:0];
   endfunction

   generate
      if (PAD_W > 0) begin : g_pad
         assign match_ext = {{PAD_W{1'b0}}, match_q};
         assign count_ext = {{PAD_W{1'b0}}, count_q};
      end else begin : g_full
         assign match_ext = match_q;
         assign count_ext = count_q;
      end
   endgenerate

   assign zero_req = wr_en && hit(bus_addr, OFS_ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= '0;
         ctrl_q  <= '0;
         presc_q <= '0;
      end else if (wr_en) begin
         if (hit(bus_addr, OFS_MATCH)) match_q <= bus_wdata[CNT_W-1:0];
         if (hit(bus_addr, OFS_CTRL))  ctrl_q  <= bus_wdata[1:0];
         if (hit(bus_addr, OFS_PRESC)) presc_q <= bus_wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit(bus_addr, OFS_MATCH)) rd_mux = match_ext;
      if (hit(bus_addr, OFS_COUNT)) rd_mux = count_ext;
      if (hit(bus_addr, OFS_CTRL))  rd_mux[1:0] = ctrl_q;
      if (hit(bus_addr, OFS_PRESC)) rd_mux[DIV_W-1:0] = presc_q;
      if (hit(bus_addr, OFS_STAT))  rd_mux[PEND_POS] = pending;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (rd_en)
         bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/mm_match_timer.sv
module mm_match_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int DIV_W       = 2,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W < 8 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("CNT_W must be within 8..32");
      end
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must be within 1..8");
      end
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
         $error("ADDR_W must be within 5..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] match_q, count_q;
   ctrl_t            ctrl_q;
   logic [DIV_W-1:0] presc_q;
   logic             zero_req, zero_apply, pending, tick;

   tmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count_q(count_q),
      .pending(pending), .match_q(match_q), .ctrl_q(ctrl_q),
      .presc_q(presc_q), .zero_req(zero_req), .bus_rdata(bus_rdata)
   );

   tmr_prescale #(.DIV_W(DIV_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .setting(presc_q), .tick(tick)
   );

   tmr_zero_sync #(.SYNC_STAGES(SYNC_STAGES)) u_zero (
      .clk(clk), .rst_n(rst_n), .tick(tick), .zero_req(zero_req),
      .zero_apply(zero_apply), .pending(pending)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q.run),
      .zero_on_match(ctrl_q.zero_on_match), .match_val(match_q),
      .zero_apply(zero_apply), .count_q(count_q), .irq(irq)
   );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              tick,
   input logic              run,
   input logic              zero_apply,
   input logic              pending,
   input logic [CNT_W-1:0]  count_q,
   input logic [CNT_W-1:0]  match_q,
   input logic              irq
);
   p_irq_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (count_q == $past(match_q)));

   p_pend_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == OFS_ZERO[ADDR_W-1:0]) |=> pending);

   p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count_q));

   p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !zero_apply) |=> $stable(count_q));

   p_zero_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
      zero_apply |=> (count_q == '0));

   p_zero_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      zero_apply |=> !irq);
endmodule

bind mm_match_timer tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .tick(tick), .run(ctrl_q.run),
   .zero_apply(zero_apply), .pending(pending), .count_q(count_q),
   .match_q(match_q), .irq(irq)
);

// File: tb/sim_mm_match_timer.sv
`timescale 1ns/1ps
module sim_mm_match_timer;
   localparam int CW    = 12;
   localparam int AW    = 5;
   localparam int MASK  = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq;

   int total = 0;
   int bad = 0;
   int irq_seen = 0;
   bit finished = 0;
   string cur_tag = "R2";

   always #2 clk = ~clk;

   mm_match_timer #(.CNT_W(CW), .DIV_W(2), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq)
   );

   // behavioural reference model, advanced at each rising edge
   int m_phase, m_presc, m_cnt, m_match, m_zero_stage, m_ack_wait;
   bit m_run, m_zom, m_pend, m_irq, m_rv;
   logic [31:0] m_rd;
   string m_tag;

   always @(posedge clk) begin
      bit t;
      bit ap;
      if (!rst_n) begin
         m_phase = 0; m_presc = 0; m_cnt = 0; m_match = 0;
         m_zero_stage = 0; m_ack_wait = 0;
         m_run = 0; m_zom = 0; m_pend = 0; m_irq = 0; m_rv = 0; m_rd = 0;
      end else begin
         t  = (m_phase == m_presc);
         ap = t && (m_zero_stage == 2);
         m_rv = bus_sel && !bus_wr;
         if (m_rv) begin
            m_tag = cur_tag;
            case (bus_addr)
               5'h00:   m_rd = m_match;
               5'h04:   m_rd = m_cnt;
               5'h08:   m_rd = {m_zom, m_run};
               5'h10:   m_rd = m_presc;
               5'h14:   m_rd = m_pend ? 32'h400 : 32'h0;
               default: m_rd = 0;
            endcase
         end
         m_irq = 0;
         if (ap) m_cnt = 0;
         else if (t && m_run) begin
            if (m_zom && m_cnt == m_match) m_cnt = 0;
            else m_cnt = (m_cnt + 1) & MASK;
            m_irq = (m_cnt == m_match);
         end
         if (m_ack_wait > 0) begin
            m_ack_wait--;
            if (m_ack_wait == 0) m_pend = 0;
         end
         if (t) begin
            if (m_zero_stage == 2) begin m_zero_stage = 0; m_ack_wait = 2; end
            else if (m_zero_stage == 1) m_zero_stage = 2;
         end
         m_phase = t ? 0 : ((m_phase + 1) & 3);
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               5'h00: m_match = bus_wdata & MASK;
               5'h08: begin m_run = bus_wdata[0]; m_zom = bus_wdata[1]; end
               5'h0C: begin m_zero_stage = 1; m_pend = 1; end
               5'h10: m_presc = bus_wdata & 3;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(irq === m_irq, "R6 irq", irq, m_irq);
         if (irq) irq_seen++;
         if (m_rv) chk(bus_rdata === m_rd, m_tag, bus_rdata, m_rd);
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag, output logic [31:0] d);
      @(negedge clk);
      cur_tag = tag;
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      @(negedge clk);
      bus_sel = 0;
      #0.5 d = bus_rdata;
   endtask

   task automatic wait_zero();
      logic [31:0] s;
      for (int k = 0; k < 60; k++) begin
         rd(5'h14, "R10 pending", s);
         if (!s[10]) break;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] c0;
      int pulses;
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk(irq === 1'b0, "R1 irq", irq, 0);
      rd(5'h00, "R1 match", d);
      rd(5'h04, "R1 count", d);
      rd(5'h08, "R1 ctrl", d);
      rd(5'h10, "R1 presc", d);
      rd(5'h14, "R1 status", d);
      // R2/R3 full-rate counting
      wr(5'h00, 32'd2000);
      wr(5'h08, 32'h1);
      repeat (13) @(negedge clk);
      rd(5'h04, "R3 count d0", d);
      rd(5'h08, "R2 ctrl", d);
      // R4 stopped holds
      wr(5'h08, 32'h0);
      rd(5'h04, "R4 count", c0);
      repeat (9) @(negedge clk);
      rd(5'h04, "R4 count", d);
      chk(d == c0, "R4 hold", d, c0);
      // R3 divide by 4 and by 2
      wr(5'h10, 32'h3);
      rd(5'h10, "R2 presc", d);
      wr(5'h08, 32'h1);
      repeat (21) @(negedge clk);
      rd(5'h04, "R3 count d3", d);
      wr(5'h10, 32'h1);
      repeat (17) @(negedge clk);
      rd(5'h04, "R3 count d1", d);
      // R9/R10 zeroing while stopped, arbitrary data
      wr(5'h08, 32'h0);
      wr(5'h0C, 32'hDEADBEEF);
      rd(5'h14, "R10 pending high", d);
      chk(d[10] === 1'b1, "R10 pending set", d[10], 1);
      wait_zero();
      rd(5'h04, "R9 count zero", d);
      chk(d == 0, "R9 zeroed", d, 0);
      // R11 ignored write, write-only read
      wr(5'h04, 32'h123);
      rd(5'h04, "R11 count unchanged", d);
      chk(d == 0, "R11 count write", d, 0);
      rd(5'h0C, "R11 strobe reads zero", d);
      // R6/R8/R5 free running, match and wrap
      wr(5'h10, 32'h0);
      wr(5'h00, 32'd20);
      irq_seen = 0;
      wr(5'h08, 32'h1);
      repeat (40) @(negedge clk);
      chk(irq_seen == 1, "R6 one pulse", irq_seen, 1);
      repeat (4200) @(negedge clk);
      chk(irq_seen == 2, "R8 pulse after wrap", irq_seen, 2);
      rd(5'h04, "R5 count after wrap", d);
      chk(d < 32'd200, "R5 wrapped", d, 0);
      // R7 zero on match at divide-by-2
      wr(5'h08, 32'h0);
      wr(5'h0C, 32'h0);
      wait_zero();
      wr(5'h00, 32'd5);
      wr(5'h10, 32'h1);
      irq_seen = 0;
      wr(5'h08, 32'h3);
      repeat (120) @(negedge clk);
      pulses = irq_seen;
      chk(pulses >= 9 && pulses <= 11, "R7 periodic pulses", pulses, 10);
      rd(5'h04, "R7 count bounded", d);
      chk(d <= 5, "R7 bound", d, 5);
      // R12 zeroing sweeps against match at full rate
      wr(5'h10, 32'h0);
      wr(5'h00, 32'd6);
      for (int off = 0; off < 24; off++) begin
         repeat (off) @(negedge clk);
         wr(5'h0C, off);
         wait_zero();
         rd(5'h04, "R12 count after zero", d);
      end
      wr(5'h08, 32'h1);
      for (int off = 0; off < 16; off++) begin
         repeat (off + 3) @(negedge clk);
         wr(5'h0C, 32'hFFFFFFFF);
         wait_zero();
      end
      repeat (5) @(negedge clk);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule